// File: doc/BRIEF.md
# Interlaced field fetch address generator

This block produces the sequence of 32-bit word addresses used to read one field of a display window out of a linear frame buffer. At the start of each field it takes one of two base addresses: the long-field base or the short-field base, as chosen by a field-select input. From that base it walks the window line by line. Each pixel request inside an armed line yields one word address. The last word of each line is flagged, and the following line begins at that last address plus a programmable modulo.

Window width, window height and the modulo all come packed in one 32-bit size word. Width and height are stored minus one. Width is counted in whole 32-bit words, because every line is padded up to a word boundary.

For progressive output the modulo is 1, so lines follow one another in memory. For interlaced output the modulo is 1 plus the line length in words and the height is half the vertical resolution. Each field then skips the lines of the other field. The timing generator supplies the field, line-start and pixel-request strobes. Memory arbitration and pixel unpacking belong to other blocks.

Top module: `ffag_top`

## Requirements
- R1: After reset `addr_valid` and `addr_last` are 0, and no strobe produces an address until the first `field_start`.
- R2: `size_cfg` packs width-in-words minus one in bits 9:0, height-in-lines minus one in bits 19:10 and the line-end modulo in bits 31:20.
- R3: A `field_start` with `field_long`=1 starts the field at `base_long`; with `field_long`=0 it starts at `base_short`. The first address of the field equals that base.
- R4: Each `pix_req` accepted inside an armed line gives `addr_valid`=1 in the following cycle. Within a line, successive addresses rise by one.
- R5: The address of word number width-1 of a line carries `addr_last`=1. The first address of the next line is that address plus the modulo.
- R6: A line is armed only by `line_start`. A `pix_req` outside an armed line gives no address. A `line_start` inside an armed line neither restarts nor extends it.
- R7: After height lines the field is finished. `line_start` and `pix_req` then give no address until the next `field_start`.
- R8: The bases and `size_cfg` are taken only at `field_start`. Changing them in mid-field has no effect on that field.
- R9: `field_start` takes priority. A `pix_req` in the same cycle gives no address, and any armed line is dropped.
- R10: A `line_start` in the same cycle as the fetch of a line's last word arms the next line, so lines can run back to back with no idle cycle.
- R11: With modulo 1+W, height H and the short base set to the long base plus W, the two fields together cover the 2·W·H words above the long base exactly once each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_long | input | ADDR_W | Word address where the long field starts |
| base_short | input | ADDR_W | Word address where the short field starts |
| size_cfg | input | 32 | Packed modulo, height minus one, width minus one |
| field_start | input | 1 | Strobe that begins a new field |
| field_long | input | 1 | Selects the long-field base at `field_start` |
| line_start | input | 1 | Strobe that arms the next line |
| pix_req | input | 1 | Request for the next word of the armed line |
| addr_valid | output | 1 | `addr` holds a new fetch address this cycle |
| addr | output | ADDR_W | Word address to fetch |
| addr_last | output | 1 | This address is the last word of its line |

## Verification
Two functions can fall in the same cycle. The first pair is the fetch of a line's final word, which closes the line and applies the modulo, together with the `line_start` that arms the next line. The bench provokes this by pulsing `line_start` alongside the last `pix_req` of each line in back-to-back rows. It judges the result by requiring the next cycle's request to return the first word of the following line at the modulo step. The second collision is a `field_start` that lands on a live `pix_req` in mid-line. It is judged by the absence of an address in that cycle, the absence of one for a following unarmed request, and a fresh line that starts at the new base.

// File: rtl/ffag_pkg.sv
package ffag_pkg;

    localparam int WID_W = 10;   // width-in-words minus one
    localparam int HGT_W = 10;   // height-in-lines minus one
    localparam int MOD_W = 12;   // line-end modulo

    // Packing order is fixed: modulo at bit 20, height at bit 10, width at bit 0.
    typedef struct packed {
        logic [MOD_W-1:0] modulo;
        logic [HGT_W-1:0] hgt_m1;
        logic [WID_W-1:0] wid_m1;
    } size_t;

    localparam int SIZE_W = $bits(size_t);

endpackage

// File: rtl/ffag_span_ctr.sv
module ffag_span_ctr #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] last_val,
    output logic [CW-1:0] cnt,
    output logic          at_last
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign at_last = (cnt_q == last_val);
    assign cnt     = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ffag_cfg_hold.sv
module ffag_cfg_hold
    import ffag_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sel_long,
    input  logic [ADDR_W-1:0] base_long,
    input  logic [ADDR_W-1:0] base_short,
    input  size_t             size_in,
    output size_t             size_out,
    output logic [ADDR_W-1:0] base_sel
);

    size_t size_d, size_q;

    assign base_sel = sel_long ? base_long : base_short;
    assign size_out = size_q;

    always_comb begin
        size_d = size_q;
        if (load) begin
            size_d = size_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= '0;
        end else begin
            size_q <= size_d;
        end
    end

endmodule

// File: rtl/ffag_top.sv
module ffag_top
    import ffag_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_long,
    input  logic [ADDR_W-1:0] base_short,
    input  logic [31:0]       size_cfg,
    input  logic              field_start,
    input  logic              field_long,
    input  logic              line_start,
    input  logic              pix_req,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last
);

    typedef struct packed {
        logic              field_run;
        logic              line_on;
        logic [ADDR_W-1:0] cur;
        logic              vld;
        logic              last;
        logic [ADDR_W-1:0] out_addr;
    } state_t;

    state_t st_d, st_q;

    size_t             size_q;
    logic [ADDR_W-1:0] base_sel;
    logic [WID_W-1:0]  word_cnt;
    logic [HGT_W-1:0]  line_cnt;
    logic              word_last;
    logic              line_final;
    logic              fetch;
    logic              line_end;
    logic              field_end;

    ffag_cfg_hold #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (field_start),
        .sel_long   (field_long),
        .base_long  (base_long),
        .base_short (base_short),
        .size_in    (size_t'(size_cfg[SIZE_W-1:0])),
        .size_out   (size_q),
        .base_sel   (base_sel)
    );

    ffag_span_ctr #(.CW(WID_W)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (field_start),
        .inc      (fetch),
        .last_val (size_q.wid_m1),
        .cnt      (word_cnt),
        .at_last  (word_last)
    );

    ffag_span_ctr #(.CW(HGT_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (field_start),
        .inc      (line_end),
        .last_val (size_q.hgt_m1),
        .cnt      (line_cnt),
        .at_last  (line_final)
    );

    assign fetch     = pix_req && st_q.line_on && !field_start;
    assign line_end  = fetch && word_last;
    assign field_end = line_end && line_final;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = fetch;
        st_d.last = line_end;
        if (fetch) begin
            st_d.out_addr = st_q.cur;
        end
        if (field_start) begin
            st_d.field_run = 1'b1;
            st_d.line_on   = 1'b0;
            st_d.cur       = base_sel;
        end else begin
            if (fetch) begin
                st_d.cur = line_end
                         ? st_q.cur + ADDR_W'(size_q.modulo)
                         : st_q.cur + ADDR_W'(1);
            end
            if (line_end) begin
                st_d.line_on = 1'b0;
            end
            if (field_end) begin
                st_d.field_run = 1'b0;
            end
            if (line_start && st_d.field_run) begin
                st_d.line_on = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_valid = st_q.vld;
    assign addr_last  = st_q.last;
    assign addr       = st_q.out_addr;

endmodule

// File: rtl/ffag_chk.sv
module ffag_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              field_start,
    input logic              pix_req,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_last
);

    p_valid_from_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> $past(pix_req));

    p_last_is_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid);

    p_field_start_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(field_start) |-> !addr_valid);

    p_step_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && $past(addr_valid) && !$past(addr_last))
            |-> (addr == $past(addr) + ADDR_W'(1)));

endmodule

bind ffag_top ffag_chk #(.ADDR_W(ADDR_W)) u_ffag_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .pix_req     (pix_req),
    .addr_valid  (addr_valid),
    .addr        (addr),
    .addr_last   (addr_last)
);

// File: tb/test_ffag_top.sv
module test_ffag_top;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] base_long = '0;
    logic [AW-1:0] base_short = '0;
    logic [31:0]   size_cfg = '0;
    logic          field_start = 1'b0;
    logic          field_long = 1'b0;
    logic          line_start = 1'b0;
    logic          pix_req = 1'b0;
    logic          addr_valid;
    logic [AW-1:0] addr;
    logic          addr_last;

    int checks = 0;
    int errors = 0;

    logic          pend_v = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic          pend_l = 1'b0;
    string         pend_r = "R1";

    int seen [0:29];

    always #2 clk = ~clk;   // 250 MHz

    ffag_top #(.ADDR_W(AW)) i_ffag_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_long   (base_long),
        .base_short  (base_short),
        .size_cfg    (size_cfg),
        .field_start (field_start),
        .field_long  (field_long),
        .line_start  (line_start),
        .pix_req     (pix_req),
        .addr_valid  (addr_valid),
        .addr        (addr),
        .addr_last   (addr_last)
    );

    typedef struct packed {
        logic          fl;
        logic [AW-1:0] bl;
        logic [AW-1:0] bs;
        logic [9:0]    w;
        logic [9:0]    h;
        logic [11:0]   m;
        logic          b2b;
    } vec_t;

    // Rows 4 and 5 form an interlaced pair (R11): modulo 1+W, short base = long base + W.
    localparam vec_t VECS [6] = '{
        '{1'b1, 24'd1000, 24'd5000, 10'd4, 10'd3, 12'd1,  1'b0},
        '{1'b0, 24'd1000, 24'd5000, 10'd4, 10'd3, 12'd1,  1'b1},
        '{1'b1, 24'd200,  24'd0,    10'd1, 10'd2, 12'd1,  1'b0},
        '{1'b1, 24'd300,  24'd0,    10'd3, 10'd2, 12'd9,  1'b1},
        '{1'b1, 24'd100,  24'd105,  10'd5, 10'd3, 12'd6,  1'b1},
        '{1'b0, 24'd100,  24'd105,  10'd5, 10'd3, 12'd6,  1'b0}
    };

    function automatic logic [31:0] pack_size(int w, int h, int m);
        logic [31:0] v;
        v = '0;
        v[9:0]   = 10'(w - 1);   // R2 width minus one
        v[19:10] = 10'(h - 1);   // R2 height minus one
        v[31:20] = 12'(m);       // R2 modulo
        return v;
    endfunction

    task automatic fail_line(string req);
        errors++;
        $display("FAIL %s: vld=%b addr=%0d last=%b expected vld=%b addr=%0d last=%b",
                 req, addr_valid, addr, addr_last, pend_v, pend_a, pend_l);
    endtask

    task automatic check_pending();
        checks++;
        if (addr_valid !== pend_v ||
            (pend_v && (addr !== pend_a || addr_last !== pend_l))) begin
            fail_line(pend_r);
        end
    endtask

    // One cycle: check the result of the previous cycle, then drive new strobes.
    task automatic step(input logic fs, input logic fl, input logic ls, input logic pr,
                        input logic ev, input logic [AW-1:0] ea, input logic el,
                        input string req);
        @(negedge clk);
        check_pending();
        field_start = fs;
        field_long  = fl;
        line_start  = ls;
        pix_req     = pr;
        pend_v = ev;
        pend_a = ea;
        pend_l = el;
        pend_r = req;
    endtask

    task automatic idle(string req);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, req);
    endtask

    task automatic run_row(vec_t v, bit track);
        int w, h, m, stride;
        logic [AW-1:0] base, a;
        w = int'(v.w); h = int'(v.h); m = int'(v.m);
        stride = w - 1 + m;
        base = v.fl ? v.bl : v.bs;
        base_long  = v.bl;
        base_short = v.bs;
        size_cfg   = pack_size(w, h, m);
        step(1'b1, v.fl, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R3");
        for (int ln = 0; ln < h; ln++) begin
            if (!v.b2b || ln == 0) begin
                step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R6");
            end
            for (int k = 0; k < w; k++) begin
                logic lst, arm;
                lst = (k == w - 1);
                arm = v.b2b && lst && (ln < h - 1);
                a = base + AW'(ln * stride + k);
                // R3 first word at base, R4 step of one, R5 last flag and modulo, R10 back to back
                step(1'b0, 1'b0, arm, 1'b1, 1'b1, a, lst,
                     lst ? (arm ? "R10" : "R5") : "R4");
                if (track && a >= 100 && a < 130) seen[a - 100]++;
            end
        end
        // R7: field is finished
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R7");
        idle("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (addr_valid !== 1'b0 || addr_last !== 1'b0) begin
            errors++;
            $display("FAIL R1: vld=%b last=%b expected vld=0 last=0", addr_valid, addr_last);
        end
        rst_n = 1'b1;
        idle("R1");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R1");
        idle("R1");

        // Table walk
        for (int i = 0; i < 30; i++) seen[i] = 0;
        for (int r = 0; r < 6; r++) begin
            run_row(VECS[r], r >= 4);
        end
        // R11: the two interlaced fields tile the window exactly once
        for (int i = 0; i < 30; i++) begin
            checks++;
            if (seen[i] != 1) begin
                errors++;
                $display("FAIL R11: address %0d fetched %0d times expected 1", 100 + i, seen[i]);
            end
        end

        // R6 and R8: unarmed request, line_start mid-line, config change mid-field
        base_long = 24'd2000;
        size_cfg  = pack_size(3, 2, 1);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R3");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd2000, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 24'd2001, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd2002, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R6");
        base_long = 24'd9000;
        size_cfg  = pack_size(7, 5, 40);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd2003, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd2004, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd2005, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R8");

        // R9: field_start on a live request in mid-line
        base_long = 24'd3000;
        size_cfg  = pack_size(4, 2, 1);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd3000, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd3001, 1'b0, "R9");
        base_short = 24'd4000;
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd4000, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 24'd4001, 1'b0, "R9");
        idle("R9");
        idle("R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule